// File: doc/BRIEF.md
# Eight-Region Memory Protection Unit

This unit sits between a processor core and its memory system and decides, for every data read, data write and instruction fetch, whether the access may go ahead. Software programs eight protection regions. Each region has an enable, a power-of-two size and a base address. Per-region permission nibbles are kept separately for code and for data. Per-region cacheable and write-buffer bits say how a granted access should be treated by the cache. A control register holds the global enable and the separate enables for the instruction and data cache attributes.

An access is presented on the request port for one cycle. The unit looks up the highest-numbered enabled region that contains the address and decodes that region's permission nibble for the access kind and the privilege mode. One cycle later it returns a response: grant, a data abort strobe for a denied data access, the matched region, the cacheable and write-buffer flags, and a write policy. A small two-state machine (IDLE, RESP) owns the response timing. The REQ transition moves IDLE or RESP to RESP on a sampled request. The DRAIN transition moves RESP back to IDLE when no request is present.

Configuration uses a simple write port with a register select, and a combinational read port with its own select. The read port also offers a compressed view of each permission word, with two bits per region.

Top module: `mpu_unit`

## Requirements
- R1: After reset, every configuration select reads 0, the unit is disabled and `rsp_valid` is 0.
- R2: Register selects are: 0 control, 1 data cacheable, 2 code cacheable, 3 data write-buffer, 4 data permissions, 5 code permissions, 6 compressed data permissions, 7 compressed code permissions, 8+n region n. Control keeps only bits 0 (enable), 2 (data attributes) and 12 (code attributes). Selects 1 to 3 keep bits [7:0], with region n at bit n. A region register keeps bit 0 (enable), bits [5:1] (size field) and bits [31:12] (base). All other bits read as 0.
- R3: Reading select 6 or 7 returns the low two bits of region n's nibble at bits [2n+1:2n]. Writing select 6 or 7 sets each nibble n to {2'b00, wdata[2n+1:2n]}.
- R4: A request sampled at a clock edge gives `rsp_valid` high for the following cycle only (REQ into RESP). With no request, the next cycle has `rsp_valid` low (DRAIN to IDLE).
- R5: With control bit 0 clear, every access is granted, with `rsp_hit`=0, no cache attributes and write policy 0.
- R6: A region covers 2^(size+1) bytes, with a 4 KiB minimum. Its base is aligned down to a multiple of that span.
- R7: When enabled regions overlap, the highest-numbered one decides, and `rsp_region` reports it. Disabled regions never match.
- R8: With the unit enabled, an address in no enabled region has no permission: data accesses abort and fetches are refused.
- R9: Access kind 0 is a data read, 1 is a data write, and 2 or 3 is a fetch. Fetches use the code nibble; data accesses use the data nibble. The nibble values decode as follows: 1 gives read/write to privileged mode only; 2 gives privileged read/write and user read; 3 gives read/write to both modes; every other value gives no access. Reads and fetches need read right and writes need write right. `acc_user`=1 marks user mode.
- R10: `rsp_abort` is high exactly when a valid response is a denied data access. A refused fetch gives `rsp_grant`=0 without an abort.
- R11: The code cacheable flag applies only when control bit 12 is set. The data cacheable and write-buffer flags apply only when control bit 2 is set. All attributes are 0 when the access is not granted.
- R12: For data accesses, `rsp_wpol` is 0 (memory only) when not cacheable, 1 (memory and cache) when cacheable without write-buffer, and 2 (cache only) when both are set. For fetches `rsp_wpol` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Write register select |
| cfg_wdata | input | 32 | Write data |
| cfg_rsel | input | 4 | Read register select |
| cfg_rdata | output | 32 | Read data (combinational) |
| acc_valid | input | 1 | Access request present |
| acc_kind | input | 2 | 0 data read, 1 data write, 2/3 fetch |
| acc_addr | input | 32 | Access address |
| acc_user | input | 1 | 1 = user mode, 0 = privileged |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access permitted |
| rsp_abort | output | 1 | Data abort strobe |
| rsp_hit | output | 1 | Some enabled region matched |
| rsp_region | output | 3 | Deciding region |
| rsp_cacheable | output | 1 | Cacheable attribute |
| rsp_wbuf | output | 1 | Data write-buffer attribute |
| rsp_wpol | output | 2 | Data write policy |

## Verification
The bench aims at the size clamp, where fields below 11 must still give a 4 KiB span. A design that used the raw field would leave small regions missing. A base written off its natural alignment must be rounded down; a design that compared the raw base would miss the lower part of such a region. The bench also tests overlaps, where choosing the lowest region would apply the wrong permissions. It checks that control enables and the compressed permission view write through correctly. It also checks that denied fetches never raise the data abort, which a design aborting on every denial would get wrong.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
    parameter int NUM_RGN   = 8;
    parameter int ADDR_W    = 32;
    parameter int PERM_W    = 4;
    parameter int SEL_W     = 4;
    parameter int MIN_SHIFT = 12;

    localparam int RGN_IDX_W = $clog2(NUM_RGN);

    localparam logic [SEL_W-1:0] SEL_CTRL     = 4'd0;
    localparam logic [SEL_W-1:0] SEL_DCACHE   = 4'd1;
    localparam logic [SEL_W-1:0] SEL_ICACHE   = 4'd2;
    localparam logic [SEL_W-1:0] SEL_WBUF     = 4'd3;
    localparam logic [SEL_W-1:0] SEL_DPERM    = 4'd4;
    localparam logic [SEL_W-1:0] SEL_CPERM    = 4'd5;
    localparam logic [SEL_W-1:0] SEL_DPERM_PK = 4'd6;
    localparam logic [SEL_W-1:0] SEL_CPERM_PK = 4'd7;

    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_DC_BIT = 2;
    localparam int CTRL_IC_BIT = 12;

    typedef enum logic [1:0] {
        ACC_DREAD  = 2'd0,
        ACC_DWRITE = 2'd1,
        ACC_FETCH  = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        WPOL_MEM   = 2'd0,
        WPOL_BOTH  = 2'd1,
        WPOL_CACHE = 2'd2
    } wpol_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;
endpackage

// File: rtl/mpu_regfile.sv
module mpu_regfile
    import mpu_pkg::*;
#(
    parameter int NREG = NUM_RGN,
    parameter int AW   = ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [AW-1:0]        cfg_wdata,
    input  logic [SEL_W-1:0]     cfg_rsel,
    output logic [AW-1:0]        cfg_rdata,
    output logic                 ctrl_en,
    output logic                 ctrl_dc,
    output logic                 ctrl_ic,
    output logic [NREG-1:0]      dcache_bits,
    output logic [NREG-1:0]      icache_bits,
    output logic [NREG-1:0]      wbuf_bits,
    output logic [NREG*PERM_W-1:0] dperm,
    output logic [NREG*PERM_W-1:0] cperm,
    output logic [NREG*AW-1:0]   rgn_flat
);
    localparam int PW = NREG * PERM_W;
    localparam int CW = NREG * 2;
    localparam logic [AW-1:0] RGN_KEEP  = {{(AW-MIN_SHIFT){1'b1}}, 6'b0, 6'b111111};
    localparam logic [AW-1:0] CTRL_KEEP = (AW'(1) << CTRL_EN_BIT) | (AW'(1) << CTRL_DC_BIT)
                                        | (AW'(1) << CTRL_IC_BIT);

    logic [AW-1:0]   ctrl_q;
    logic [NREG-1:0] dc_q, ic_q, wb_q;
    logic [PW-1:0]   dp_q, cp_q;
    logic [AW-1:0]   rgn_q [NREG];
    logic [CW-1:0]   dp_pk, cp_pk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            dc_q   <= '0;
            ic_q   <= '0;
            wb_q   <= '0;
            dp_q   <= '0;
            cp_q   <= '0;
            for (int n = 0; n < NREG; n++) rgn_q[n] <= '0;
        end else if (cfg_we) begin
            if (cfg_sel[SEL_W-1]) begin
                rgn_q[cfg_sel[RGN_IDX_W-1:0]] <= cfg_wdata & RGN_KEEP;
            end else begin
                case (cfg_sel)
                    SEL_CTRL:   ctrl_q <= cfg_wdata & CTRL_KEEP;
                    SEL_DCACHE: dc_q   <= cfg_wdata[NREG-1:0];
                    SEL_ICACHE: ic_q   <= cfg_wdata[NREG-1:0];
                    SEL_WBUF:   wb_q   <= cfg_wdata[NREG-1:0];
                    SEL_DPERM:  dp_q   <= cfg_wdata[PW-1:0];
                    SEL_CPERM:  cp_q   <= cfg_wdata[PW-1:0];
                    SEL_DPERM_PK: begin
                        for (int n = 0; n < NREG; n++)
                            dp_q[PERM_W*n +: PERM_W] <= {2'b00, cfg_wdata[2*n +: 2]};
                    end
                    SEL_CPERM_PK: begin
                        for (int n = 0; n < NREG; n++)
                            cp_q[PERM_W*n +: PERM_W] <= {2'b00, cfg_wdata[2*n +: 2]};
                    end
                    default: ;
                endcase
            end
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_pack
        assign dp_pk[2*g +: 2]     = dp_q[PERM_W*g +: 2];
        assign cp_pk[2*g +: 2]     = cp_q[PERM_W*g +: 2];
        assign rgn_flat[AW*g +: AW] = rgn_q[g];
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_rsel[SEL_W-1]) begin
            cfg_rdata = rgn_q[cfg_rsel[RGN_IDX_W-1:0]];
        end else begin
            case (cfg_rsel)
                SEL_CTRL:     cfg_rdata = ctrl_q;
                SEL_DCACHE:   cfg_rdata = AW'(dc_q);
                SEL_ICACHE:   cfg_rdata = AW'(ic_q);
                SEL_WBUF:     cfg_rdata = AW'(wb_q);
                SEL_DPERM:    cfg_rdata = AW'(dp_q);
                SEL_CPERM:    cfg_rdata = AW'(cp_q);
                SEL_DPERM_PK: cfg_rdata = AW'(dp_pk);
                SEL_CPERM_PK: cfg_rdata = AW'(cp_pk);
                default:      cfg_rdata = '0;
            endcase
        end
    end

    assign ctrl_en     = ctrl_q[CTRL_EN_BIT];
    assign ctrl_dc     = ctrl_q[CTRL_DC_BIT];
    assign ctrl_ic     = ctrl_q[CTRL_IC_BIT];
    assign dcache_bits = dc_q;
    assign icache_bits = ic_q;
    assign wbuf_bits   = wb_q;
    assign dperm       = dp_q;
    assign cperm       = cp_q;

    // R3
    pk_write_clears_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && (cfg_sel == SEL_DPERM_PK) |=> (dp_q[3:2] == 2'b00) && (dp_q[31:30] == 2'b00));
endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
    import mpu_pkg::*;
#(
    parameter int NREG = NUM_RGN,
    parameter int AW   = ADDR_W
) (
    input  logic [AW-1:0]          addr,
    input  logic [NREG*AW-1:0]     rgn_flat,
    output logic                   hit,
    output logic [RGN_IDX_W-1:0]   idx
);
    localparam int SHW = $clog2(AW + 1) + 1;

    logic [NREG-1:0] match;

    for (genvar g = 0; g < NREG; g++) begin : g_rgn
        logic [AW-1:0]  rr;
        logic [AW-1:0]  base;
        logic [SHW-1:0] raw_sh;
        logic [SHW-1:0] sh;
        logic [AW:0]    span_mask;

        assign rr        = rgn_flat[AW*g +: AW];
        assign base      = {rr[AW-1:MIN_SHIFT], {MIN_SHIFT{1'b0}}};
        assign raw_sh    = SHW'(rr[5:1]) + SHW'(1);
        assign sh        = (raw_sh < SHW'(MIN_SHIFT)) ? SHW'(MIN_SHIFT) : raw_sh;
        assign span_mask = {(AW+1){1'b1}} << sh;
        assign match[g]  = rr[0] && (((addr ^ base) & span_mask[AW-1:0]) == '0);
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int n = 0; n < NREG; n++) begin
            if (match[n]) begin
                hit = 1'b1;
                idx = RGN_IDX_W'(n);
            end
        end
    end
endmodule

// File: rtl/mpu_perm_decode.sv
module mpu_perm_decode
    import mpu_pkg::*;
(
    input  logic [PERM_W-1:0] nib,
    input  logic              user,
    output logic              can_rd,
    output logic              can_wr
);
    always_comb begin
        can_rd = 1'b0;
        can_wr = 1'b0;
        case (nib)
            4'd1: begin
                can_rd = !user;
                can_wr = !user;
            end
            4'd2: begin
                can_rd = 1'b1;
                can_wr = !user;
            end
            4'd3: begin
                can_rd = 1'b1;
                can_wr = 1'b1;
            end
            default: begin
                can_rd = 1'b0;
                can_wr = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mpu_unit.sv
module mpu_unit
    import mpu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [3:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic [3:0]  cfg_rsel,
    output logic [31:0] cfg_rdata,
    input  logic        acc_valid,
    input  logic [1:0]  acc_kind,
    input  logic [31:0] acc_addr,
    input  logic        acc_user,
    output logic        rsp_valid,
    output logic        rsp_grant,
    output logic        rsp_abort,
    output logic        rsp_hit,
    output logic [2:0]  rsp_region,
    output logic        rsp_cacheable,
    output logic        rsp_wbuf,
    output logic [1:0]  rsp_wpol
);
    localparam int PW = NUM_RGN * PERM_W;

    logic                 ctrl_en, ctrl_dc, ctrl_ic;
    logic [NUM_RGN-1:0]   dc_bits, ic_bits, wb_bits;
    logic [PW-1:0]        dperm, cperm;
    logic [NUM_RGN*ADDR_W-1:0] rgn_flat;
    logic                 m_hit;
    logic [RGN_IDX_W-1:0] m_idx;
    logic [PERM_W-1:0]    sel_nib;
    logic                 can_rd, can_wr;

    mpu_regfile #(.NREG(NUM_RGN), .AW(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
        .ctrl_en(ctrl_en), .ctrl_dc(ctrl_dc), .ctrl_ic(ctrl_ic),
        .dcache_bits(dc_bits), .icache_bits(ic_bits), .wbuf_bits(wb_bits),
        .dperm(dperm), .cperm(cperm), .rgn_flat(rgn_flat)
    );

    mpu_region_match #(.NREG(NUM_RGN), .AW(ADDR_W)) match_i (
        .addr(acc_addr), .rgn_flat(rgn_flat), .hit(m_hit), .idx(m_idx)
    );

    logic is_fetch;
    assign is_fetch = acc_kind[1];
    assign sel_nib  = is_fetch ? cperm[PERM_W*m_idx +: PERM_W] : dperm[PERM_W*m_idx +: PERM_W];

    mpu_perm_decode perm_i (
        .nib(sel_nib), .user(acc_user), .can_rd(can_rd), .can_wr(can_wr)
    );

    // Combinational decision for the access on the request port.
    logic                 d_grant, d_abort, d_hit, d_cach, d_wbuf;
    logic [RGN_IDX_W-1:0] d_region;
    wpol_e                d_wpol;

    always_comb begin
        d_grant  = 1'b1;
        d_hit    = 1'b0;
        d_region = '0;
        d_cach   = 1'b0;
        d_wbuf   = 1'b0;
        d_wpol   = WPOL_MEM;
        if (ctrl_en) begin
            d_hit    = m_hit;
            d_region = m_idx;
            d_grant  = m_hit && ((acc_kind == ACC_DWRITE) ? can_wr : can_rd);
            if (d_grant) begin
                if (is_fetch) begin
                    d_cach = ctrl_ic && ic_bits[m_idx];
                end else begin
                    d_cach = ctrl_dc && dc_bits[m_idx];
                    d_wbuf = ctrl_dc && wb_bits[m_idx];
                    if (d_cach) d_wpol = d_wbuf ? WPOL_CACHE : WPOL_BOTH;
                end
            end
        end
        d_abort = !is_fetch && !d_grant;
    end

    // Response state machine: state register.
    rsp_state_e st_q, st_d;

    always_comb begin
        unique case (st_q)
            ST_IDLE: st_d = acc_valid ? ST_RESP : ST_IDLE;
            ST_RESP: st_d = acc_valid ? ST_RESP : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Response holding registers, loaded on every sampled request.
    logic                 grant_q, abort_q, hit_q, cach_q, wbuf_q;
    logic [RGN_IDX_W-1:0] region_q;
    wpol_e                wpol_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_q  <= 1'b0;
            abort_q  <= 1'b0;
            hit_q    <= 1'b0;
            region_q <= '0;
            cach_q   <= 1'b0;
            wbuf_q   <= 1'b0;
            wpol_q   <= WPOL_MEM;
        end else if (acc_valid) begin
            grant_q  <= d_grant;
            abort_q  <= d_abort;
            hit_q    <= d_hit;
            region_q <= d_region;
            cach_q   <= d_cach;
            wbuf_q   <= d_wbuf;
            wpol_q   <= d_wpol;
        end
    end

    // Output process.
    always_comb begin
        rsp_valid     = 1'b0;
        rsp_abort     = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                rsp_valid = 1'b0;
                rsp_abort = 1'b0;
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                rsp_abort = abort_q;
            end
            default: ;
        endcase
        rsp_grant     = grant_q;
        rsp_hit       = hit_q;
        rsp_region    = region_q;
        rsp_cacheable = cach_q;
        rsp_wbuf      = wbuf_q;
        rsp_wpol      = wpol_q;
    end

    // R4
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);

    // R4
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);

    // R10
    abort_needs_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_abort |-> rsp_valid && !rsp_grant);

    // R10
    fetch_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_kind[1] |=> !rsp_abort);

    // R5
    off_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !ctrl_en |=> rsp_grant && !rsp_hit && !rsp_cacheable);

    // R11
    attr_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_cacheable || rsp_wbuf) |-> rsp_grant);

    // R12
    cache_only_wpol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_wpol == 2'd2) |-> rsp_cacheable && rsp_wbuf);
endmodule

// File: tb/mpu_unit_tb.sv
module mpu_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  cfg_rsel = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [31:0] acc_addr = '0;
    logic        acc_user = 1'b0;
    logic        rsp_valid, rsp_grant, rsp_abort, rsp_hit, rsp_cacheable, rsp_wbuf;
    logic [2:0]  rsp_region;
    logic [1:0]  rsp_wpol;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mpu_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
        .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr), .acc_user(acc_user),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_abort(rsp_abort),
        .rsp_hit(rsp_hit), .rsp_region(rsp_region), .rsp_cacheable(rsp_cacheable),
        .rsp_wbuf(rsp_wbuf), .rsp_wpol(rsp_wpol)
    );

    // Behavioural reference state.
    logic [31:0] m_ctrl, m_dc, m_cc, m_wb, m_dp, m_cp;
    logic [31:0] m_rg [8];

    function automatic logic [31:0] m_read(input int sel);
        logic [31:0] r;
        r = 0;
        if (sel >= 8) return m_rg[sel-8];
        case (sel)
            0: r = m_ctrl;
            1: r = m_dc;
            2: r = m_cc;
            3: r = m_wb;
            4: r = m_dp;
            5: r = m_cp;
            6: for (int n = 0; n < 8; n++) r[2*n +: 2] = m_dp[4*n +: 2];
            7: for (int n = 0; n < 8; n++) r[2*n +: 2] = m_cp[4*n +: 2];
            default: r = 0;
        endcase
        return r;
    endfunction

    function automatic void m_write(input int sel, input logic [31:0] d);
        if (sel >= 8) m_rg[sel-8] = d & 32'hFFFFF03F;
        else case (sel)
            0: m_ctrl = d & 32'h00001005;
            1: m_dc = d & 32'hFF;
            2: m_cc = d & 32'hFF;
            3: m_wb = d & 32'hFF;
            4: m_dp = d;
            5: m_cp = d;
            6: for (int n = 0; n < 8; n++) m_dp[4*n +: 4] = {2'b00, d[2*n +: 2]};
            7: for (int n = 0; n < 8; n++) m_cp[4*n +: 4] = {2'b00, d[2*n +: 2]};
            default: ;
        endcase
    endfunction

    function automatic bit m_inside(input int n, input logic [31:0] a);
        longint span, lo;
        int e;
        if (!m_rg[n][0]) return 0;
        e = int'(m_rg[n][5:1]) + 1;
        if (e < 12) e = 12;
        span = longint'(1) << e;
        lo = (longint'(m_rg[n]) & 64'hFFFFF000) / span * span;
        return (longint'(a) >= lo) && (longint'(a) < lo + span);
    endfunction

    // Returns {grant, abort, hit, region[2:0], cach, wbuf, wpol[1:0]}.
    function automatic logic [9:0] m_eval(input logic [1:0] k, input logic [31:0] a, input bit u);
        bit g, ab, h, c, w, rd, wr;
        int reg_n, nib;
        logic [1:0] p;
        g = 1; h = 0; reg_n = 0; c = 0; w = 0; p = 0;
        if (m_ctrl[0]) begin
            for (int n = 0; n < 8; n++) if (m_inside(n, a)) begin h = 1; reg_n = n; end
            nib = k[1] ? int'(m_cp[4*reg_n +: 4]) : int'(m_dp[4*reg_n +: 4]);
            rd = (nib == 3) || (nib == 2) || (nib == 1 && !u);
            wr = (nib == 3) || ((nib == 1 || nib == 2) && !u);
            g = h && ((k == 2'd1) ? wr : rd);
            if (g) begin
                if (k[1]) c = m_ctrl[12] && m_cc[reg_n];
                else begin
                    c = m_ctrl[2] && m_dc[reg_n];
                    w = m_ctrl[2] && m_wb[reg_n];
                    if (c) p = w ? 2'd2 : 2'd1;
                end
            end
        end
        ab = !k[1] && !g;
        return {g, ab, h, 3'(reg_n), c, w, p};
    endfunction

    // One clock: drive at a falling edge, predict, compare at the next falling edge.
    task automatic step(input bit av, input logic [1:0] k, input logic [31:0] a, input bit u,
                        input bit we, input int sel, input logic [31:0] wd, input string tag);
        logic [9:0] exp_v, act_v;
        bit exp_valid;
        acc_valid = av; acc_kind = k; acc_addr = a; acc_user = u;
        cfg_we = we; cfg_sel = 4'(sel); cfg_wdata = wd;
        exp_valid = av;
        exp_v = m_eval(k, a, u);
        if (we) m_write(sel, wd);
        @(negedge clk);
        checks++;
        act_v = {rsp_grant, rsp_abort, rsp_hit, rsp_region, rsp_cacheable, rsp_wbuf, rsp_wpol};
        if (rsp_valid !== exp_valid) begin
            fails++;
            $display("FAIL %s: rsp_valid actual %b expected %b", tag, rsp_valid, exp_valid);
        end else if (exp_valid && act_v !== exp_v) begin
            fails++;
            $display("FAIL %s: kind %0d addr %h user %0d response actual %b expected %b",
                     tag, k, a, u, act_v, exp_v);
        end else if (!exp_valid && rsp_abort !== 1'b0) begin
            fails++;
            $display("FAIL %s: idle abort actual %b expected 0", tag, rsp_abort);
        end
        acc_valid = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic wr(input int sel, input logic [31:0] d, input string tag);
        step(1'b0, 2'd0, 32'h0, 1'b0, 1'b1, sel, d, tag);
    endtask

    task automatic acc(input logic [1:0] k, input logic [31:0] a, input bit u, input string tag);
        step(1'b1, k, a, u, 1'b0, 0, 32'h0, tag);
    endtask

    task automatic rd_chk(input int sel, input string tag);
        logic [31:0] e;
        cfg_rsel = 4'(sel);
        #1;
        e = m_read(sel);
        checks++;
        if (cfg_rdata !== e) begin
            fails++;
            $display("FAIL %s: select %0d read actual %h expected %h", tag, sel, cfg_rdata, e);
        end
    endtask

    logic [31:0] pool [10];

    initial begin
        m_ctrl = 0; m_dc = 0; m_cc = 0; m_wb = 0; m_dp = 0; m_cp = 0;
        for (int n = 0; n < 8; n++) m_rg[n] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int s = 0; s < 16; s++) rd_chk(s, "R1");
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: rsp_valid actual %b expected 0", rsp_valid);
        end

        // R5: unit disabled grants everything
        wr(8, 32'h0000003F, "R5");
        wr(9, 32'h00000000, "R5");
        acc(2'd1, 32'h12345678, 1'b1, "R5");
        acc(2'd2, 32'hFFFF0000, 1'b1, "R5");

        // R2: kept bits
        wr(0, 32'hFFFFFFFF, "R2"); rd_chk(0, "R2");
        wr(1, 32'hFFFFFFFF, "R2"); rd_chk(1, "R2");
        wr(12, 32'hFFFFFFFF, "R2"); rd_chk(12, "R2");
        wr(5, 32'hA5A5A5A5, "R2"); rd_chk(5, "R2");

        // R3: compressed views
        wr(4, 32'h76543210, "R3"); rd_chk(6, "R3");
        wr(7, 32'h0000E4E4, "R3"); rd_chk(5, "R3"); rd_chk(7, "R3");

        // Main configuration
        wr(0, 32'h00001005, "R11");
        wr(8,  32'h0000003F, "R6");   // whole space
        wr(9,  32'h0200002B, "R6");   // 4 MiB at 0x02000000
        wr(10, 32'h0200100B, "R6");   // size 5 clamps to 4 KiB
        wr(11, 32'h02001016, "R7");   // disabled
        wr(12, 32'h0800301B, "R6");   // 16 KiB, base rounds down
        wr(13, 32'h00000000, "R7");
        wr(14, 32'h00000000, "R7");
        wr(15, 32'h00000000, "R7");
        wr(4, 32'h00003231, "R9");
        wr(5, 32'h00030021, "R9");
        wr(1, 32'h00000006, "R11");
        wr(2, 32'h00000002, "R11");
        wr(3, 32'h00000004, "R12");

        // R6 / R7 / R9 / R10 / R12 directed
        acc(2'd0, 32'h02000FFC, 1'b0, "R12");
        acc(2'd1, 32'h02001000, 1'b0, "R7");
        acc(2'd1, 32'h02001000, 1'b1, "R9");
        acc(2'd0, 32'h02001FFF, 1'b1, "R6");
        acc(2'd0, 32'h02002000, 1'b1, "R6");
        acc(2'd1, 32'h08000000, 1'b0, "R6");
        acc(2'd2, 32'h08003FFC, 1'b0, "R10");
        acc(2'd2, 32'h08004000, 1'b0, "R6");
        acc(2'd0, 32'h00000100, 1'b1, "R9");
        acc(2'd3, 32'h02000040, 1'b1, "R11");

        // R8: no region
        wr(8, 32'h0000003E, "R8");
        acc(2'd0, 32'h40000000, 1'b0, "R8");
        acc(2'd2, 32'h40000000, 1'b0, "R8");
        acc(2'd1, 32'h02000010, 1'b0, "R8");

        // R11: attribute gating by control
        wr(0, 32'h00000001, "R11");
        acc(2'd0, 32'h02000010, 1'b0, "R11");
        acc(2'd2, 32'h02000010, 1'b0, "R11");
        wr(0, 32'h00001005, "R11");
        acc(2'd0, 32'h02000010, 1'b0, "R11");

        // R4: back-to-back then idle, with a config write on the same edge
        acc(2'd0, 32'h02000020, 1'b0, "R4");
        step(1'b1, 2'd1, 32'h02000030, 1'b1, 1'b1, 4, 32'h0, "R4");
        acc(2'd1, 32'h02000030, 1'b1, "R4");
        step(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 0, 32'h0, "R4");
        wr(4, 32'h00003231, "R4");
        wr(8, 32'h0000003F, "R4");

        // Mixed patterns over interesting addresses
        pool[0] = 32'h00000000; pool[1] = 32'h02000000; pool[2] = 32'h02001000;
        pool[3] = 32'h02001800; pool[4] = 32'h023FFFFC; pool[5] = 32'h02400000;
        pool[6] = 32'h08002000; pool[7] = 32'h08004000; pool[8] = 32'hFFFFFFFC;
        pool[9] = 32'h02000800;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            a = pool[$urandom_range(0, 9)];
            if (i % 50 == 25) begin
                int s;
                s = $urandom_range(0, 15);
                step(1'b1, 2'($urandom_range(0, 3)), a, 1'($urandom_range(0, 1)),
                     1'b1, s, $urandom, "R7");
            end else if (i % 7 == 3) begin
                step(1'b0, 2'd0, a, 1'b0, 1'b0, 0, 32'h0, "R4");
            end else begin
                acc(2'($urandom_range(0, 3)), a, 1'($urandom_range(0, 1)), "R9");
            end
        end
        for (int s = 0; s < 16; s++) rd_chk(s, "R2");

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run did not finish, actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule